// File: doc/BRIEF.md
# Burst Address and Byte-Strobe Generator

This block walks a write burst on a bus with a 32-bit data path. It takes a start pulse with a start address, a transfer size code and a burst code. It then produces the address of every beat and the byte-lane write strobe that goes with it. An advance handshake from the surrounding bus logic steps the burst forward one beat at a time. A beat counter and a last-beat flag tell the master side when a fixed-length burst is done.

The strobe comes from the byte offset of each beat address and the transfer size. Narrow beats therefore use only some of the byte lanes. In a wrapping burst they move between lower and upper lanes and then fold back to the wrap boundary. An unaligned first beat enables lanes from its own offset up to the end of its size-aligned container. A mode input forces every lane on, for masters that do not drive strobes.

Top module: `burst_beat_gen`

## Requirements
- R1: After reset, and whenever no burst is active, `active_o`, `last_o` and `beat_o` are zero and `strb_o` is 4'b0000.
- R2: A start pulse with size code 0 (byte), 1 (half-word) or 2 (word) makes the next cycle show `active_o`=1, `addr_o` equal to the start address and `beat_o`=0.
- R3: The beat address and beat counter change only on a cycle where `advance_i` is high while a burst is active. The next address is the current address rounded down to a multiple of the transfer byte count (2^size), plus that byte count, modulo 2^ADDR_W.
- R4: In a wrapping burst the span is beats × bytes per beat. The wrap boundary is the start address rounded down to a multiple of the span, and the upper limit is the boundary plus the span. A next address equal to the upper limit becomes the boundary instead.
- R5: Burst code 0 is a single beat and 1 is incrementing of undefined length. Codes 2, 4 and 6 are wrapping bursts of 4, 8 and 16 beats, and codes 3, 5 and 7 are incrementing bursts of 4, 8 and 16 beats. `beat_o` counts beats from 0 and steps by one on each advance (modulo 32).
- R6: On the first beat, strobe bit i (byte lane i, data bits 8i+7:8i) is set for lower ≤ i ≤ upper and clear otherwise. Here lower is the start address modulo 4, and upper is the size-aligned start address modulo 4, plus the byte count, minus 1.
- R7: On every later beat, lower is the beat address modulo 4 and upper is lower plus the byte count minus 1, with the same bit rule as R6. For half-word beats, offset 0 gives 4'b0011 and offset 2 gives 4'b1100.
- R8: While `strb_all_i` is high, `strb_o` is 4'b1111 on every active beat, whatever the address and size.
- R9: A start pulse with a size code above 2 is rejected. On the next cycle `active_o` is 0 and `strb_o` is 4'b0000, even if a burst was running.
- R10: `last_o` is high exactly on the final beat of a fixed-length burst and never during an undefined-length burst. An advance while `last_o` is high ends the burst, so `active_o` is 0 on the next cycle.
- R11: A start pulse during an active burst reloads all state. The next cycle shows the new start address with `beat_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new burst with the values below |
| start_addr_i | input | ADDR_W | Byte address of the first beat |
| size_i | input | 3 | Transfer size code, bytes = 2^size |
| burst_i | input | 3 | Burst type and length code |
| advance_i | input | 1 | Current beat accepted, step to the next |
| strb_all_i | input | 1 | Force all strobe lanes on |
| active_o | output | 1 | A burst is in progress |
| addr_o | output | ADDR_W | Address of the current beat |
| strb_o | output | DATA_BYTES | Byte-lane write strobe of the current beat |
| beat_o | output | 5 | Index of the current beat |
| last_o | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
The bench builds the block with ADDR_W set to 16 and DATA_BYTES left at 4. The narrow address lets an incrementing word burst started at 0xFFF8 roll over through 0x0000, which exercises the modulo rule of R3 in a few beats. The 4-byte bus keeps every lane pattern visible: byte beats walking single lanes, half-word beats alternating halves, and unaligned first beats with truncated strobes. Wrapping bursts of all three lengths and sizes are placed so that the fold to the boundary falls in the middle of the burst.

// File: rtl/burst_pkg.sv
package burst_pkg;

  localparam int SIZE_W  = 3;
  localparam int BURST_W = 3;
  localparam int BEAT_W  = 5;

  typedef struct packed {
    logic       wrap;
    logic       fixed;
    logic [2:0] beats_log2;
  } burst_info_t;

endpackage

// File: rtl/burst_decode.sv
module burst_decode
  import burst_pkg::*;
(
  input  logic [BURST_W-1:0] code_i,
  output burst_info_t        info_o
);

  always_comb begin
    info_o = '0;
    if (code_i == '0) begin
      info_o.fixed      = 1'b1;
      info_o.beats_log2 = 3'd0;
    end else if (code_i == BURST_W'(1)) begin
      info_o.fixed      = 1'b0;
      info_o.beats_log2 = 3'd0;
    end else begin
      info_o.fixed      = 1'b1;
      info_o.wrap       = ~code_i[0];
      info_o.beats_log2 = {1'b0, code_i[2:1]} + 3'd1;
    end
  end

endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step
  import burst_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              wrap_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  output logic [ADDR_W-1:0] next_o
);

  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] inc;

  always_comb begin
    step   = ADDR_W'(1) << size_i;
    inc    = (addr_i & ~(step - ADDR_W'(1))) + step;
    next_o = (wrap_i && (inc == hi_i)) ? lo_i : inc;
  end

endmodule

// File: rtl/lane_strobe.sv
module lane_strobe
  import burst_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int ADDR_W     = 32
) (
  input  logic                  active_i,
  input  logic                  first_i,
  input  logic                  force_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [SIZE_W-1:0]     size_i,
  output logic [DATA_BYTES-1:0] strb_o
);

  localparam int OFF_W = $clog2(DATA_BYTES);

  logic [OFF_W:0] low;
  logic [OFF_W:0] nb_m1;
  logic [OFF_W:0] aligned_off;
  logic [OFF_W:0] up;

  always_comb begin
    low         = {1'b0, addr_i[OFF_W-1:0]};
    nb_m1       = (OFF_W+1)'((1 << size_i) - 1);
    aligned_off = low & ~nb_m1;
    up          = first_i ? (aligned_off + nb_m1) : (low + nb_m1);
  end

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
    logic in_range;
    assign in_range  = ((OFF_W+1)'(g) >= low) && ((OFF_W+1)'(g) <= up);
    assign strb_o[g] = active_i & (force_i | in_range);
  end

endmodule

// File: rtl/burst_beat_gen.sv
module burst_beat_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [ADDR_W-1:0]     start_addr_i,
  input  logic [SIZE_W-1:0]     size_i,
  input  logic [BURST_W-1:0]    burst_i,
  input  logic                  advance_i,
  input  logic                  strb_all_i,
  output logic                  active_o,
  output logic [ADDR_W-1:0]     addr_o,
  output logic [DATA_BYTES-1:0] strb_o,
  output logic [BEAT_W-1:0]     beat_o,
  output logic                  last_o
);

  localparam int MAX_SIZE = $clog2(DATA_BYTES);

  burst_info_t       info_new, info_q, info_d;
  logic              active_q, active_d;
  logic              first_q, first_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic [SIZE_W-1:0] size_q, size_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [ADDR_W-1:0] addr_next;
  logic [BEAT_W-1:0] beats_m1;
  logic [3:0]        span_log2;
  logic [ADDR_W-1:0] wrap_lo, wrap_hi;
  logic              size_ok;
  logic              last_beat;
  logic              ld_en;

  burst_decode u_decode (
    .code_i (burst_i),
    .info_o (info_new)
  );

  burst_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .addr_i (addr_q),
    .size_i (size_q),
    .wrap_i (info_q.wrap),
    .lo_i   (lo_q),
    .hi_i   (hi_q),
    .next_o (addr_next)
  );

  lane_strobe #(.DATA_BYTES(DATA_BYTES), .ADDR_W(ADDR_W)) u_strb (
    .active_i (active_q),
    .first_i  (first_q),
    .force_i  (strb_all_i),
    .addr_i   (addr_q),
    .size_i   (size_q),
    .strb_o   (strb_o)
  );

  always_comb begin
    size_ok   = (size_i <= SIZE_W'(MAX_SIZE));
    span_log2 = {1'b0, info_new.beats_log2} + {1'b0, size_i};
    wrap_lo   = start_addr_i & ({ADDR_W{1'b1}} << span_log2);
    wrap_hi   = wrap_lo + (ADDR_W'(1) << span_log2);
    beats_m1  = (BEAT_W'(1) << info_q.beats_log2) - BEAT_W'(1);
    last_beat = active_q & info_q.fixed & (beat_q == beats_m1);
    ld_en     = start_i | (active_q & advance_i);
  end

  // next-state
  always_comb begin
    active_d = active_q;
    first_d  = first_q;
    addr_d   = addr_q;
    lo_d     = lo_q;
    hi_d     = hi_q;
    size_d   = size_q;
    info_d   = info_q;
    beat_d   = beat_q;
    if (start_i) begin
      beat_d = '0;
      if (size_ok) begin
        active_d = 1'b1;
        first_d  = 1'b1;
        addr_d   = start_addr_i;
        lo_d     = wrap_lo;
        hi_d     = wrap_hi;
        size_d   = size_i;
        info_d   = info_new;
      end else begin
        active_d = 1'b0;
        first_d  = 1'b0;
      end
    end else if (active_q && advance_i) begin
      if (last_beat) begin
        active_d = 1'b0;
        first_d  = 1'b0;
        beat_d   = '0;
      end else begin
        addr_d  = addr_next;
        beat_d  = beat_q + BEAT_W'(1);
        first_d = 1'b0;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      first_q  <= 1'b0;
      addr_q   <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      size_q   <= '0;
      info_q   <= '0;
      beat_q   <= '0;
    end else if (ld_en) begin
      active_q <= active_d;
      first_q  <= first_d;
      addr_q   <= addr_d;
      lo_q     <= lo_d;
      hi_q     <= hi_d;
      size_q   <= size_d;
      info_q   <= info_d;
      beat_q   <= beat_d;
    end
  end

  assign active_o = active_q;
  assign addr_o   = addr_q;
  assign beat_o   = active_q ? beat_q : '0;
  assign last_o   = last_beat;

  // R1
  idle_strb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |-> (strb_o == '0) && !last_o);

  // R7
  strb_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> (strb_o != '0));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !advance_i && !start_i) |=> ($stable(addr_o) && $stable(beat_o)));

  // R5
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && advance_i && !last_o && !start_i) |=> (beat_o == $past(beat_o) + BEAT_W'(1)));

  // R4
  wrap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && info_q.wrap) |-> ((addr_q - lo_q) < (hi_q - lo_q)));

  // R9
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (size_i > SIZE_W'(MAX_SIZE))) |=> !active_o);

  // R10
  last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && advance_i && !start_i) |=> !active_o);

endmodule

// File: tb/burst_beat_gen_test.sv
module burst_beat_gen_test;

  localparam int AW = 16;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [AW-1:0] start_addr_i;
  logic [2:0]    size_i;
  logic [2:0]    burst_i;
  logic          advance_i;
  logic          strb_all_i;
  logic          active_o;
  logic [AW-1:0] addr_o;
  logic [3:0]    strb_o;
  logic [4:0]    beat_o;
  logic          last_o;

  int checks = 0;
  int errors = 0;
  bit mon_on = 0;

  typedef struct {
    logic [AW-1:0] a;
    logic [3:0]    s;
    int            b;
    logic          l;
    logic          frc;
    logic          first;
    string         t;
  } exp_t;

  exp_t exp_q[$];

  burst_beat_gen #(.ADDR_W(AW), .DATA_BYTES(4)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .size_i       (size_i),
    .burst_i      (burst_i),
    .advance_i    (advance_i),
    .strb_all_i   (strb_all_i),
    .active_o     (active_o),
    .addr_o       (addr_o),
    .strb_o       (strb_o),
    .beat_o       (beat_o),
    .last_o       (last_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  function automatic int n_beats(input logic [2:0] bu);
    if (bu == 3'd0) return 1;
    if (bu == 3'd1) return 0;
    return 4 << ((bu >> 1) - 1);
  endfunction

  function automatic logic [3:0] model_strb(input logic [AW-1:0] a, input logic [2:0] sz,
                                            input logic first, input logic frc);
    int lo, nb, al, up;
    logic [3:0] s;
    if (frc) return 4'hF;
    lo = int'(a[1:0]);
    nb = 1 << sz;
    al = lo & ~(nb - 1);
    up = first ? al + nb - 1 : lo + nb - 1;
    s = '0;
    for (int i = 0; i < 4; i++) if (i >= lo && i <= up) s[i] = 1'b1;
    return s;
  endfunction

  function automatic logic [AW-1:0] model_next(input logic [AW-1:0] a, input logic [2:0] sz,
                                               input logic [2:0] bu, input logic [AW-1:0] st);
    logic [AW-1:0] nb, inc, span, lo;
    nb  = AW'(1) << sz;
    inc = (a & ~(nb - AW'(1))) + nb;
    if (bu >= 3'd2 && !bu[0]) begin
      span = AW'(n_beats(bu)) * nb;
      lo   = st & ~(span - AW'(1));
      if (inc == lo + span) inc = lo;
    end
    return inc;
  endfunction

  // driver: pushes expected beats, then drives the burst with advance held high
  task automatic run_burst(input logic [AW-1:0] a, input logic [2:0] sz, input logic [2:0] bu,
                           input logic frc, input int n, input string tag);
    logic [AW-1:0] cur;
    bit undef;
    int m;
    exp_t e;
    undef = (bu == 3'd1);
    m = undef ? n + 1 : n;
    cur = a;
    for (int i = 0; i < m; i++) begin
      e.a = cur; e.s = model_strb(cur, sz, (i == 0), frc); e.b = i % 32;
      e.l = !undef && (i == n - 1); e.frc = frc; e.first = (i == 0); e.t = tag;
      exp_q.push_back(e);
      cur = model_next(cur, sz, bu, a);
    end
    mon_on = 1;
    @(posedge clk); #1;
    start_i = 1; start_addr_i = a; size_i = sz; burst_i = bu; strb_all_i = frc;
    @(posedge clk); #1;
    start_i = 0; advance_i = 1;
    repeat (n) @(posedge clk);
    #1;
    advance_i = 0;
    if (undef) begin start_i = 1; size_i = 3'd3; end
    @(posedge clk); #1;
    start_i = 0;
    @(negedge clk);
    mon_on = 0;
    strb_all_i = 0;
    chk(!active_o, undef ? "R9" : "R10", {tag, " idle after burst"}, int'(active_o), 0);
    chk(exp_q.size() == 0, "R5", {tag, " beats left unseen"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on && active_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "beat after burst end", int'(addr_o), 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(addr_o == e.a, e.t, "beat address", int'(addr_o), int'(e.a));
        chk(strb_o == e.s, e.frc ? "R8" : (e.first ? "R6" : "R7"), {e.t, " strobe"},
            int'(strb_o), int'(e.s));
        chk(int'(beat_o) == e.b, "R5", {e.t, " beat index"}, int'(beat_o), e.b);
        chk(last_o == e.l, "R10", {e.t, " last flag"}, int'(last_o), int'(e.l));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; start_i = 0; start_addr_i = '0; size_i = '0; burst_i = '0;
    advance_i = 0; strb_all_i = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!active_o, "R1", "active after reset", int'(active_o), 0);
    chk(strb_o == 4'h0, "R1", "strobe after reset", int'(strb_o), 0);
    chk(!last_o, "R1", "last after reset", int'(last_o), 0);
    chk(beat_o == 5'd0, "R1", "beat after reset", int'(beat_o), 0);

    // R4 wrap16 half-word from 0x30: folds 0x3E -> 0x20, strobes alternate (R7)
    run_burst(16'h0030, 3'd1, 3'd6, 1'b0, 16, "R4");
    // R3 unaligned word incr4 at 0x31: first 1110 (R6)
    run_burst(16'h0031, 3'd2, 3'd3, 1'b0, 4, "R3");
    // R6 half-word incr8 at 0x33: first 1000
    run_burst(16'h0033, 3'd1, 3'd5, 1'b0, 8, "R6");
    // R4 byte wrap8 at 0x05: 5,6,7,0..4
    run_burst(16'h0005, 3'd0, 3'd4, 1'b0, 8, "R4");
    // R4 word wrap4 at 0x38: 38,3C,30,34
    run_burst(16'h0038, 3'd2, 3'd2, 1'b0, 4, "R4");
    // R5 single byte beat
    run_burst(16'h0002, 3'd0, 3'd0, 1'b0, 1, "R5");
    // R3 incr16 word rolling over the top of the address space
    run_burst(16'hFFF8, 3'd2, 3'd7, 1'b0, 16, "R3");
    // R8 forced strobes, half-word incr4
    run_burst(16'h0012, 3'd1, 3'd3, 1'b1, 4, "R8");
    // R10 undefined-length byte burst, ended by rejected start (R9)
    run_burst(16'h0010, 3'd0, 3'd1, 1'b0, 6, "R10");

    // R2 / R3 hold without advance
    @(posedge clk); #1;
    start_i = 1; start_addr_i = 16'h0100; size_i = 3'd2; burst_i = 3'd3;
    @(posedge clk); #1;
    start_i = 0;
    @(negedge clk);
    chk(active_o, "R2", "active after start", int'(active_o), 1);
    chk(addr_o == 16'h0100, "R2", "first address", int'(addr_o), 'h100);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(addr_o == 16'h0100, "R3", "address held", int'(addr_o), 'h100);
    chk(beat_o == 5'd0, "R3", "beat held", int'(beat_o), 0);
    @(posedge clk); #1 advance_i = 1;
    @(posedge clk); #1 advance_i = 0;
    @(negedge clk);
    chk(addr_o == 16'h0104, "R3", "single advance", int'(addr_o), 'h104);
    chk(beat_o == 5'd1, "R5", "beat after advance", int'(beat_o), 1);

    // R11 reload mid-burst
    @(posedge clk); #1;
    start_i = 1; start_addr_i = 16'h0088; size_i = 3'd2; burst_i = 3'd2;
    @(posedge clk); #1 start_i = 0;
    @(negedge clk);
    chk(addr_o == 16'h0088, "R11", "reload address", int'(addr_o), 'h88);
    chk(beat_o == 5'd0, "R11", "reload beat", int'(beat_o), 0);
    chk(strb_o == 4'hF, "R11", "reload strobe", int'(strb_o), 'hF);

    // R9 reject while active
    @(posedge clk); #1;
    start_i = 1; size_i = 3'd4;
    @(posedge clk); #1 start_i = 0;
    @(negedge clk);
    chk(!active_o, "R9", "rejected start idles", int'(active_o), 0);
    chk(strb_o == 4'h0, "R9", "strobe after reject", int'(strb_o), 0);

    // R9 reject while idle
    @(posedge clk); #1;
    start_i = 1; start_addr_i = 16'h0040; size_i = 3'd3;
    @(posedge clk); #1 start_i = 0;
    @(negedge clk);
    chk(!active_o, "R9", "idle reject stays idle", int'(active_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule